// File: doc/BRIEF.md
# Sequential Matrix Multiply Engine

The engine forms the product C = A × B of two square matrices of signed cells. All three matrices live in internal single-port memories laid out row-major. The work is spread over many clock cycles instead of being built as one wide combinational array. There is exactly one multiplier and one adder. Row, column and inner-product indices are held in registers and step once per cycle.

A host fills A and B through a valid/ready load port, then pulses `start`. The engine first writes zero into every result word, one word per cycle. It then streams one product per cycle into an accumulator and writes each finished element of C. When the last element is stored, `ready` rises and stays high. The host can then fetch C through a valid/ready read port whose response arrives one cycle after acceptance.

Back-pressure is simple and state-based. Both `ld_ready` and `rd_ready` are high whenever the engine is idle or done. Both are low for the whole clear and compute run, and an offer made while they are low is not taken. Neither port stalls while the engine is idle or done.

Top module: `matmul_engine`

## Requirements
- R1: After reset, `ready` and `rsp_valid` are low while `ld_ready` and `rd_ready` are high.
- R2: An accepted `start` first writes zero into all DIM² result words, one word per cycle, before any product is formed.
- R3: Every port address is row-major: element (r,c) sits at address r·DIM+c. `ld_sel`=0 selects A and `ld_sel`=1 selects B.
- R4: Result word (i,j) is the sum over k of A(i,k)·B(k,j). The cells are two's-complement signed, and the result is 2·CELL_W bits wide, wrapping modulo 2^(2·CELL_W).
- R5: `ready` is first high exactly DIM² + DIM³ + 2 clock edges after the edge that accepts `start`.
- R6: `ready` rises only in the cycle after the last result word (address DIM²−1) has been written.
- R7: `ready` stays high until a new `start` is accepted. A `start` while done begins a new run, and `ready` is low after that edge.
- R8: While the engine is busy, `ld_ready` and `rd_ready` are low. A load offered during that time does not change A or B, and a `start` offered during that time does not restart the run or change its timing.
- R9: A read accepted on an edge (`rd_valid` and `rd_ready` both high) gives `rsp_valid` high for exactly the following cycle, with `rsp_data` holding the addressed word of C.
- R10: A load is accepted on an edge where `ld_valid` and `ld_ready` are both high, and it writes `ld_data` at `ld_addr` in the matrix that `ld_sel` selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; taken only when idle or done |
| ready | output | 1 | High while the result is complete |
| ld_valid | input | 1 | Load offer valid |
| ld_ready | output | 1 | Load offer can be taken |
| ld_sel | input | 1 | Target matrix: 0 = A, 1 = B |
| ld_addr | input | ADDR_W | Row-major cell address |
| ld_data | input | CELL_W | Signed cell value |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request can be taken |
| rd_addr | input | ADDR_W | Row-major address in C |
| rsp_valid | output | 1 | Read data valid, one cycle after acceptance |
| rsp_data | output | 2·CELL_W | Signed result word |

## Verification
The bench builds the engine with DIM=4 and CELL_W=8. This keeps a whole run to 82 cycles, so every element of C can be compared with a product computed in the bench for several matrix pairs. The 8-bit cells let the bench reach both extreme negative operands and a 16-bit accumulator wrap. The small dimension also makes it cheap to inject a restart and loads in mid-run and to time the exact arrival of `ready`.

// File: rtl/matmul_pkg.sv
package matmul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CLEAR   = 2'd1,
    ST_COMPUTE = 2'd2,
    ST_DONE    = 2'd3
  } mm_state_t;
endpackage

// File: rtl/mm_spram.sv
module mm_spram #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/mm_mac.sv
module mm_mac #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           first,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] acc
);
  logic signed [2*W-1:0] a_x, b_x, prod;

  assign a_x  = $signed({{W{a[W-1]}}, a});
  assign b_x  = $signed({{W{b[W-1]}}, b});
  assign prod = a_x * b_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '0;
    else if (en)   acc <= first ? prod : acc + prod;
  end
endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl
  import matmul_pkg::*;
#(
  parameter int DIM  = 16,
  localparam int AW  = (DIM*DIM > 1) ? $clog2(DIM*DIM) : 1,
  localparam int IW  = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output mm_state_t     state,
  output logic          busy,
  output logic          clr_we,
  output logic [AW-1:0] clr_addr,
  output logic [AW-1:0] addr_a,
  output logic [AW-1:0] addr_b,
  output logic          s1_v,
  output logic          s1_first,
  output logic          c_wr,
  output logic [AW-1:0] c_waddr
);
  localparam logic [AW-1:0] LAST_W = AW'(DIM*DIM - 1);
  localparam logic [IW-1:0] LAST_I = IW'(DIM - 1);

  logic [AW-1:0] clr_cnt;
  logic [IW-1:0] ri, cj, kk;
  logic          issue_on;
  logic          s1_last;
  logic [AW-1:0] s1_caddr;

  assign busy     = (state == ST_CLEAR) || (state == ST_COMPUTE);
  assign clr_we   = (state == ST_CLEAR);
  assign clr_addr = clr_cnt;
  assign addr_a   = AW'(ri * DIM + kk);
  assign addr_b   = AW'(kk * DIM + cj);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      clr_cnt  <= '0;
      ri       <= '0;
      cj       <= '0;
      kk       <= '0;
      issue_on <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state   <= ST_CLEAR;
            clr_cnt <= '0;
          end
        end
        ST_CLEAR: begin
          clr_cnt <= clr_cnt + 1'b1;
          if (clr_cnt == LAST_W) begin
            state    <= ST_COMPUTE;
            ri       <= '0;
            cj       <= '0;
            kk       <= '0;
            issue_on <= 1'b1;
          end
        end
        ST_COMPUTE: begin
          if (issue_on) begin
            if (kk == LAST_I) begin
              kk <= '0;
              if (cj == LAST_I) begin
                cj <= '0;
                if (ri == LAST_I) issue_on <= 1'b0;
                else              ri <= ri + 1'b1;
              end else begin
                cj <= cj + 1'b1;
              end
            end else begin
              kk <= kk + 1'b1;
            end
          end
          if (c_wr && (c_waddr == LAST_W)) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
      s1_caddr <= '0;
      c_wr     <= 1'b0;
      c_waddr  <= '0;
    end else begin
      s1_v     <= issue_on && (state == ST_COMPUTE);
      s1_first <= (kk == '0);
      s1_last  <= (kk == LAST_I);
      s1_caddr <= AW'(ri * DIM + cj);
      c_wr     <= s1_v && s1_last;
      c_waddr  <= s1_caddr;
    end
  end
endmodule

// File: rtl/matmul_engine.sv
module matmul_engine
  import matmul_pkg::*;
#(
  parameter int DIM     = 16,
  parameter int CELL_W  = 8,
  localparam int ADDR_W = (DIM*DIM > 1) ? $clog2(DIM*DIM) : 1,
  localparam int RES_W  = 2*CELL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              ready,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic              ld_sel,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [CELL_W-1:0] ld_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rsp_valid,
  output logic [RES_W-1:0]  rsp_data
);
  mm_state_t         st;
  logic              busy, host_ok;
  logic              clr_we, s1_v, s1_first, c_wr;
  logic [ADDR_W-1:0] clr_addr, addr_a, addr_b, c_waddr;
  logic              a_we, b_we, c_we;
  logic [ADDR_W-1:0] a_addr, b_addr, c_addr;
  logic [CELL_W-1:0] a_q, b_q;
  logic [RES_W-1:0]  acc, c_wdata;

  mm_ctrl #(.DIM(DIM)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .state(st), .busy(busy),
    .clr_we(clr_we), .clr_addr(clr_addr), .addr_a(addr_a), .addr_b(addr_b),
    .s1_v(s1_v), .s1_first(s1_first), .c_wr(c_wr), .c_waddr(c_waddr)
  );

  assign host_ok  = !busy;
  assign ld_ready = host_ok;
  assign rd_ready = host_ok;
  assign ready    = (st == ST_DONE);

  assign a_we   = host_ok && ld_valid && !ld_sel;
  assign b_we   = host_ok && ld_valid &&  ld_sel;
  assign a_addr = host_ok ? ld_addr : addr_a;
  assign b_addr = host_ok ? ld_addr : addr_b;

  assign c_we    = clr_we || c_wr;
  assign c_addr  = clr_we ? clr_addr : (c_wr ? c_waddr : rd_addr);
  assign c_wdata = clr_we ? '0 : acc;

  mm_spram #(.DEPTH(DIM*DIM), .DW(CELL_W)) u_mem_a (
    .clk(clk), .we(a_we), .addr(a_addr), .wdata(ld_data), .rdata(a_q));
  mm_spram #(.DEPTH(DIM*DIM), .DW(CELL_W)) u_mem_b (
    .clk(clk), .we(b_we), .addr(b_addr), .wdata(ld_data), .rdata(b_q));
  mm_spram #(.DEPTH(DIM*DIM), .DW(RES_W)) u_mem_c (
    .clk(clk), .we(c_we), .addr(c_addr), .wdata(c_wdata), .rdata(rsp_data));

  mm_mac #(.W(CELL_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .en(s1_v), .first(s1_first),
    .a(a_q), .b(b_q), .acc(acc));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= host_ok && rd_valid;
  end
endmodule

// File: rtl/matmul_engine_chk.sv
module matmul_engine_chk
  import matmul_pkg::*;
#(
  parameter int DIM    = 16,
  parameter int ADDR_W = 8,
  parameter int RES_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              ready,
  input mm_state_t         st,
  input logic              busy,
  input logic              c_we,
  input logic [ADDR_W-1:0] c_addr,
  input logic [RES_W-1:0]  c_wdata,
  input logic              a_we,
  input logic              b_we,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic              rsp_valid
);
  localparam logic [ADDR_W-1:0] LAST_W = ADDR_W'(DIM*DIM - 1);

  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CLEAR) |-> (c_we && (c_wdata == '0)));

  assert_ready_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(c_we && (c_addr == LAST_W)));

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> ready);

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_COMPUTE) |=> (st != ST_CLEAR));

  assert_no_load_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(a_we || b_we));

  assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rsp_valid);

  assert_rsp_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && rd_ready) |=> !rsp_valid);
endmodule

bind matmul_engine matmul_engine_chk #(.DIM(DIM), .ADDR_W(ADDR_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .st(st), .busy(busy),
  .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata), .a_we(a_we), .b_we(b_we),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rsp_valid(rsp_valid)
);

// File: tb/matmul_engine_test.sv
`timescale 1ns/1ps
module matmul_engine_test;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int AW = 4;
  localparam int RW = 16;
  localparam int LAT = N*N + N*N*N + 2;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic ready;
  logic ld_valid = 0, ld_ready, ld_sel = 0;
  logic [AW-1:0] ld_addr = '0;
  logic [W-1:0]  ld_data = '0;
  logic rd_valid = 0, rd_ready;
  logic [AW-1:0] rd_addr = '0;
  logic rsp_valid;
  logic [RW-1:0] rsp_data;

  int tests = 0;
  int fails = 0;
  int ma [N*N];
  int mb [N*N];

  always #10 clk = ~clk;

  matmul_engine #(.DIM(N), .CELL_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_sel(ld_sel),
    .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] ref_c(input int i, input int j);
    int s = 0;
    for (int k = 0; k < N; k++) s += ma[i*N+k] * mb[k*N+j];
    return RW'(s);
  endfunction

  task automatic load_one(input bit sel, input int addr, input int val);
    @(negedge clk);
    ld_valid = 1; ld_sel = sel; ld_addr = AW'(addr); ld_data = W'(val);
    @(posedge clk);
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic load_all();
    for (int x = 0; x < N*N; x++) load_one(1'b0, x, ma[x]);
    for (int x = 0; x < N*N; x++) load_one(1'b1, x, mb[x]);
  endtask

  // R5 timing, with optional mid-run start/load/read offers (R8)
  task automatic run(input bit interfere, input string tag);
    int n = 0;
    @(negedge clk);
    start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    while (!ready && n < 1000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (interfere && n == 40) begin
        check(ld_ready == 0, "R8 ld_ready busy", int'(ld_ready), 0);
        check(rd_ready == 0, "R8 rd_ready busy", int'(rd_ready), 0);
        start = 1; ld_valid = 1; ld_sel = 0; ld_addr = '0; ld_data = 8'd99;
        rd_valid = 1;
      end
      if (interfere && n == 41) begin
        start = 0; ld_valid = 0; rd_valid = 0;
        check(rsp_valid == 0, "R8 no rsp busy", int'(rsp_valid), 0);
      end
    end
    check(n == LAT, {tag, " R5 latency"}, n, LAT);
  endtask

  task automatic read_check(input int addr, input logic [RW-1:0] exp, input string tag);
    @(negedge clk);
    rd_valid = 1; rd_addr = AW'(addr);
    @(posedge clk);
    @(negedge clk);
    rd_valid = 0;
    check(rsp_valid == 1, {tag, " R9 rsp_valid"}, int'(rsp_valid), 1);
    check(rsp_data == exp, {tag, " R4 C word"}, int'($signed(rsp_data)), int'($signed(exp)));
    @(negedge clk);
    check(rsp_valid == 0, {tag, " R9 one-cycle rsp"}, int'(rsp_valid), 0);
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        read_check(i*N+j, ref_c(i, j), tag);
  endtask

  task automatic t_reset();
    check(ready == 0, "R1 ready", int'(ready), 0);
    check(rsp_valid == 0, "R1 rsp_valid", int'(rsp_valid), 0);
    check(ld_ready == 1, "R1 ld_ready", int'(ld_ready), 1);
    check(rd_ready == 1, "R1 rd_ready", int'(rd_ready), 1);
  endtask

  task automatic t_identity();
    for (int x = 0; x < N*N; x++) begin
      ma[x] = (x / N == x % N) ? 1 : 0;
      mb[x] = x * 3 - 20;
    end
    load_all();
    run(1'b0, "identity R2 R10");
    check_all("identity R3");
  endtask

  task automatic t_signed();
    for (int x = 0; x < N*N; x++) begin
      ma[x] = ((x * 7) % 23) - 11;
      mb[x] = 13 - ((x * 5) % 29);
    end
    load_all();
    run(1'b0, "signed");
    check_all("signed R4");
  endtask

  task automatic t_wrap();
    for (int x = 0; x < N*N; x++) begin
      ma[x] = -128;
      mb[x] = (x % 2 == 0) ? -128 : 127;
    end
    load_all();
    run(1'b0, "wrap");
    check_all("wrap R4");
  endtask

  task automatic t_busy_ignored();
    for (int x = 0; x < N*N; x++) begin
      ma[x] = x - 8;
      mb[x] = (x * 11) % 17 - 5;
    end
    load_all();
    run(1'b1, "busy R8");
    check_all("busy R8");
  endtask

  task automatic t_hold_restart();
    repeat (10) @(negedge clk);
    check(ready == 1, "R7 ready held", int'(ready), 1);
    check(ld_ready == 1, "R7 ld_ready done", int'(ld_ready), 1);
    for (int x = 0; x < N*N; x++) begin
      ma[x] = (x % 5) - 2;
      mb[x] = 6 - (x % 7);
    end
    load_all();
    check(ready == 1, "R7 ready after load", int'(ready), 1);
    @(negedge clk);
    start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    check(ready == 0, "R7 ready drops on restart", int'(ready), 0);
    check(ld_ready == 0, "R8 ld_ready after restart", int'(ld_ready), 0);
    while (!ready) @(negedge clk);
    check_all("restart R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_identity();
    t_signed();
    t_wrap();
    t_busy_ignored();
    t_hold_restart();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule